// File: doc/BRIEF.md
# Prescaled 8-bit PWM Timer

This block is an 8-bit up-counter whose count enable is chosen by a three-bit clock-select code. The enable can come from the system clock, either every cycle or thinned out by a free-running prescaler, or from transitions on an external pin. The pin is first brought into the clock domain by a synchronizer. The current count can be read at all times. A code of zero freezes the counter at its present value.

A two-state output machine drives a fast, non-inverting PWM pin. The state `ST_HIGH` is entered on the `WRAP` transition, taken on every tick that moves the counter from 255 to 0. The state `ST_LOW` is entered on the `MATCH` transition, taken on the tick where the counter equals the active compare value. When a wrap and a match fall on the same tick, the wrap wins. The pin follows the state only while the waveform-mode and output-mode fields select fast non-inverting PWM. In every other setting the pin is driven low.

Compare writes land in a pending register and are copied to the active register only on a wrap, so the duty cycle can change while the timer runs without glitches. A one-cycle overflow pulse marks each wrap.

Top module: `pwm_timer8`

## Requirements
- R1: `count` is 8 bits wide and always readable. It advances by exactly one on each enabled tick, wraps from 255 to 0, and never changes by any other amount.
- R2: Clock-select code 3'b000 stops counting and holds `count` at its present value. No overflow pulse occurs while stopped.
- R3: Codes 3'b001, 3'b010, 3'b011, 3'b100 and 3'b101 give one tick every 1, 8, 64, 256 and 1024 system clocks respectively. A configuration write that changes the code restarts the prescaler, so the first increment lands on the D-th rising edge after the write edge, where D is the divisor. A write that repeats the current code does not restart it.
- R4: Code 3'b110 counts falling edges and code 3'b111 counts rising edges of `ext_pin`, exactly once per qualifying edge. The increment appears at the third rising clock edge after the pin changes. Edges of the other polarity are ignored.
- R5: `pwm_out` is driven from the output state only when `cfg_wave` = 3'b011 and `cfg_out_mode` = 2'b10. For any other pair of values `pwm_out` is 0.
- R6: In PWM mode, `pwm_out` is high exactly while `count` is less than or equal to the active compare value. A value of 0 gives one high tick per 256-tick period, 255 gives a constant high, and N gives N+1 high ticks.
- R7: A compare write takes effect only at the next wrap, so the period in progress keeps its duty. A write presented in the same cycle as the wrap edge is used for the period that starts at that wrap.
- R8: `ovf_pulse` is high for exactly one system clock, in the cycle after the edge where `count` goes from 255 to 0, which is the same cycle in which `count` reads 0.
- R9: After reset, `count` = 0, `pwm_out` = 0 and `ovf_pulse` = 0. Clock select starts at stop, and the compare values, waveform mode and output mode all start at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the three configuration fields |
| cfg_clk_sel | input | 3 | Clock-select code |
| cfg_wave | input | 3 | Waveform-mode field (3'b011 selects fast PWM) |
| cfg_out_mode | input | 2 | Compare-output-mode field (2'b10 selects non-inverting) |
| cmp_we | input | 1 | Write strobe for the pending compare value |
| cmp_wdata | input | 8 | Compare value to write |
| ext_pin | input | 1 | External count source, asynchronous |
| count | output | 8 | Current counter value |
| pwm_out | output | 1 | PWM output pin |
| ovf_pulse | output | 1 | One-cycle wrap indication |

## Verification
Two pairs of functions can meet in a single cycle. The first pair is a compare write that coincides with the wrap edge. The bench provokes it by waiting until `count` reads 255 at the system clock divisor and strobing `cmp_we` in that cycle. It then counts the high ticks of the following period against the newly written value plus one. The second pair is a clock-select change against a running prescaler. The bench provokes it by rewriting the same code in mid-interval and measuring the cycles to the next increment, which must reflect an unbroken prescaler phase. A behavioural model in the bench, updated on every clock, also judges `count`, `pwm_out` and `ovf_pulse` cycle by cycle through all of these collisions.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;

    typedef enum logic [2:0] {
        CS_STOP     = 3'b000,
        CS_DIV1     = 3'b001,
        CS_DIV8     = 3'b010,
        CS_DIV64    = 3'b011,
        CS_DIV256   = 3'b100,
        CS_DIV1024  = 3'b101,
        CS_EXT_FALL = 3'b110,
        CS_EXT_RISE = 3'b111
    } clk_sel_e;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } pwm_state_e;

    localparam logic [2:0] WAVE_FAST_PWM = 3'b011;
    localparam logic [1:0] OUT_NONINV    = 2'b10;
    localparam int         NUM_DIV       = 5;

    // log2 of each internal divisor, index 0 is the undivided clock
    function automatic int div_log2(input int idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            2:       return 6;
            3:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import pwm_timer8_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0]   pre_q;
    logic [NUM_DIV-1:0] tap_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
    end

    for (genvar gi = 0; gi < NUM_DIV; gi++) begin : g_tap
        localparam int               TapBits = div_log2(gi);
        localparam logic [PRE_W-1:0] TapMask = PRE_W'((1 << TapBits) - 1);
        assign tap_hit[gi] = ((pre_q & TapMask) == TapMask);
    end

    always_comb begin
        case (clk_sel_e'(sel))
            CS_DIV1:    tick = tap_hit[0];
            CS_DIV8:    tick = tap_hit[1];
            CS_DIV64:   tick = tap_hit[2];
            CS_DIV256:  tick = tap_hit[3];
            CS_DIV1024: tick = tap_hit[4];
            default:    tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_edge_detect.sv
module tmr_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[SYNC_STAGES-1:0], pin};
    end

    assign rise =  shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
    assign fall = ~shift_q[SYNC_STAGES-1] &  shift_q[SYNC_STAGES];

endmodule

// File: rtl/tmr_pwm_fsm.sv
module tmr_pwm_fsm
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic             pwm_en,
    output logic             pwm_out
);

    pwm_state_e state_q, state_d;
    logic       at_wrap, at_match;

    assign at_wrap  = tick && (count == '1);
    assign at_match = tick && (count == cmp_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HIGH: if (at_wrap)       state_d = ST_HIGH;  // WRAP wins
                     else if (at_match) state_d = ST_LOW;   // MATCH
            ST_LOW:  if (at_wrap)       state_d = ST_HIGH;  // WRAP
        endcase
    end

    always_comb begin
        pwm_out = pwm_en && (state_q == ST_HIGH);
    end

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_clk_sel,
    input  logic [2:0]       cfg_wave,
    input  logic [1:0]       cfg_out_mode,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             ext_pin,
    output logic [CNT_W-1:0] count,
    output logic             pwm_out,
    output logic             ovf_pulse
);

    logic [2:0]       csel_q;
    logic [2:0]       wave_q;
    logic [1:0]       omode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_pend, cmp_act, cmp_next;
    logic             ovf_q;
    logic             restart, pre_tick, ext_rise, ext_fall, tick, wrap, pwm_en;

    // R3: only a change of code restarts the prescaler
    assign restart = cfg_we && (cfg_clk_sel != csel_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csel_q  <= CS_STOP;
            wave_q  <= '0;
            omode_q <= '0;
        end else if (cfg_we) begin
            csel_q  <= cfg_clk_sel;
            wave_q  <= cfg_wave;
            omode_q <= cfg_out_mode;
        end
    end

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .sel     (csel_q),
        .tick    (pre_tick)
    );

    tmr_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    // R2, R4: source selection
    always_comb begin
        case (clk_sel_e'(csel_q))
            CS_STOP:     tick = 1'b0;
            CS_EXT_FALL: tick = ext_fall;
            CS_EXT_RISE: tick = ext_rise;
            default:     tick = pre_tick;
        endcase
    end

    assign wrap     = tick && (cnt_q == '1);
    assign cmp_next = cmp_we ? cmp_wdata : cmp_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            ovf_q    <= 1'b0;
            cmp_pend <= '0;
            cmp_act  <= '0;
        end else begin
            if (tick) cnt_q <= cnt_q + 1'b1;
            ovf_q    <= wrap;
            cmp_pend <= cmp_next;
            if (wrap) cmp_act <= cmp_next;   // R7: load at wrap, bypass same-cycle write
        end
    end

    assign pwm_en = (wave_q == WAVE_FAST_PWM) && (omode_q == OUT_NONINV);

    tmr_pwm_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .count   (cnt_q),
        .cmp_act (cmp_act),
        .pwm_en  (pwm_en),
        .pwm_out (pwm_out)
    );

    assign count     = cnt_q;
    assign ovf_pulse = ovf_q;

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       csel_q,
    input logic             tick,
    input logic [CNT_W-1:0] cmp_act,
    input logic             pwm_en,
    input logic [CNT_W-1:0] count,
    input logic             pwm_out,
    input logic             ovf_pulse
);

    a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1)));

    a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (csel_q == CS_STOP) |=> $stable(count));

    a_r6_duty_shape: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_out == (pwm_en && (count <= cmp_act)));

    a_r7_cmp_loads_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && (count == '1)) |=> $stable(cmp_act));

    a_r8_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == '0));

    a_r8_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);

endmodule

bind pwm_timer8 pwm_timer8_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csel_q    (csel_q),
    .tick      (tick),
    .cmp_act   (cmp_act),
    .pwm_en    (pwm_en),
    .count     (count),
    .pwm_out   (pwm_out),
    .ovf_pulse (ovf_pulse)
);

// File: tb/pwm_timer8_tb.sv
module pwm_timer8_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_clk_sel = '0;
    logic [2:0] cfg_wave = '0;
    logic [1:0] cfg_out_mode = '0;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic       ext_pin = 1'b0;
    logic [7:0] count;
    logic       pwm_out;
    logic       ovf_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timer8 u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_clk_sel  (cfg_clk_sel),
        .cfg_wave     (cfg_wave),
        .cfg_out_mode (cfg_out_mode),
        .cmp_we       (cmp_we),
        .cmp_wdata    (cmp_wdata),
        .ext_pin      (ext_pin),
        .count        (count),
        .pwm_out      (pwm_out),
        .ovf_pulse    (ovf_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference, updated on every clock
    int m_csel, m_wave, m_om, m_pre, m_cnt, m_act, m_pend, m_ovf, m_s1, m_s2, m_s3;

    always @(posedge clk or negedge rst_n) begin
        int t, d, pn;
        bit w;
        if (!rst_n) begin
            m_csel = 0; m_wave = 0; m_om = 0; m_pre = 0; m_cnt = 0;
            m_act = 0; m_pend = 0; m_ovf = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            t = 0;
            if (m_csel >= 1 && m_csel <= 5) begin
                d = (m_csel == 1) ? 1 : (m_csel == 2) ? 8 : (m_csel == 3) ? 64 :
                    (m_csel == 4) ? 256 : 1024;
                t = ((m_pre % d) == d - 1) ? 1 : 0;
            end else if (m_csel == 6) begin
                t = (m_s2 == 0 && m_s3 == 1) ? 1 : 0;
            end else if (m_csel == 7) begin
                t = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
            end
            w  = (t != 0) && (m_cnt == 255);
            pn = cmp_we ? int'(cmp_wdata) : m_pend;
            if (t != 0) m_cnt = (m_cnt + 1) % 256;
            m_ovf = w ? 1 : 0;
            if (w) m_act = pn;
            m_pend = pn;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ext_pin);
            if (cfg_we && int'(cfg_clk_sel) != m_csel) m_pre = 0;
            else                                       m_pre = (m_pre + 1) % 1024;
            if (cfg_we) begin
                m_csel = int'(cfg_clk_sel);
                m_wave = int'(cfg_wave);
                m_om   = int'(cfg_out_mode);
            end
        end
    end

    always @(negedge clk) begin
        int exp_pwm;
        if (rst_n && !done) begin
            exp_pwm = (m_wave == 3 && m_om == 2 && m_cnt <= m_act) ? 1 : 0;
            check(int'(count) == m_cnt, "R1 per-cycle count", int'(count), m_cnt);
            check(int'(pwm_out) == exp_pwm, "R6 per-cycle pwm_out", int'(pwm_out), exp_pwm);
            check(int'(ovf_pulse) == m_ovf, "R8 per-cycle ovf_pulse", int'(ovf_pulse), m_ovf);
        end
    end

    // called at a negedge; returns at the next negedge
    task automatic wr_cfg(input logic [2:0] cs, input logic [2:0] wv, input logic [1:0] om);
        cfg_we = 1'b1; cfg_clk_sel = cs; cfg_wave = wv; cfg_out_mode = om;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_cmp(input logic [7:0] v);
        cmp_we = 1'b1; cmp_wdata = v;
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    // counts high samples over one full period starting at count 0 (system clock divisor)
    task automatic measure_high(output int h, input int wr_at, input logic [7:0] wr_val);
        while (count != 8'd0) @(negedge clk);
        h = 0;
        for (int i = 0; i < 256; i++) begin
            if (pwm_out) h++;
            if (i == wr_at) begin cmp_we = 1'b1; cmp_wdata = wr_val; end
            @(negedge clk);
            cmp_we = 1'b0;
        end
    endtask

    task automatic cycles_to_change(output int n);
        logic [7:0] c0;
        c0 = count;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (count == c0);
    endtask

    task automatic pulse_pin(input int times);
        for (int k = 0; k < times; k++) begin
            ext_pin = 1'b1; repeat (3) @(negedge clk);
            ext_pin = 1'b0; repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check(count == 8'd0, "R9 reset count", int'(count), 0);
        check(pwm_out == 1'b0, "R9 reset pwm_out", int'(pwm_out), 0);
        check(ovf_pulse == 1'b0, "R9 reset ovf_pulse", int'(ovf_pulse), 0);
    end

    initial begin : main
        int h, n;
        logic [7:0] c;
        @(posedge rst_n);
        @(negedge clk);

        // PWM at system clock
        wr_cfg(3'b001, 3'b011, 2'b10);
        measure_high(h, -1, 8'd0);
        check(h == 1, "R6 compare 0 gives single high tick", h, 1);
        wr_cmp(8'd255);
        measure_high(h, -1, 8'd0);
        check(h == 256, "R6 compare 255 constant high", h, 256);
        wr_cmp(8'd100);
        measure_high(h, -1, 8'd0);
        check(h == 101, "R6 compare 100 duty", h, 101);

        // R7: mid-period write keeps current duty
        wr_cmp(8'd50);
        measure_high(h, -1, 8'd0);
        check(h == 51, "R6 compare 50 duty", h, 51);
        measure_high(h, 120, 8'd200);
        check(h == 51, "R7 mid-period write deferred", h, 51);
        measure_high(h, -1, 8'd0);
        check(h == 201, "R7 new value after wrap", h, 201);

        // R7: write coinciding with the wrap edge
        while (count != 8'd255) @(negedge clk);
        cmp_we = 1'b1; cmp_wdata = 8'd30;
        @(negedge clk);
        cmp_we = 1'b0;
        measure_high(h, -1, 8'd0);
        check(h == 31, "R7 write in wrap cycle applies at once", h, 31);

        // R8: two wraps in 512 cycles
        while (count != 8'd0) @(negedge clk);
        h = 0;
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            if (ovf_pulse) h++;
        end
        check(h == 2, "R8 one pulse per wrap", h, 2);

        // R5: other mode pairs keep the pin low
        wr_cfg(3'b001, 3'b000, 2'b10);
        measure_high(h, -1, 8'd0);
        check(h == 0, "R5 waveform 000 pin low", h, 0);
        wr_cfg(3'b001, 3'b111, 2'b10);
        measure_high(h, -1, 8'd0);
        check(h == 0, "R5 waveform 111 pin low", h, 0);
        wr_cfg(3'b001, 3'b011, 2'b11);
        measure_high(h, -1, 8'd0);
        check(h == 0, "R5 output mode 11 pin low", h, 0);

        // R2: stop holds the count
        wr_cfg(3'b000, 3'b011, 2'b10);
        c = count;
        h = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (ovf_pulse) h++;
        end
        check(count == c, "R2 count held while stopped", int'(count), int'(c));
        check(h == 0, "R2 no overflow while stopped", h, 0);

        // R3: latency and period per divisor
        for (int cs = 1; cs <= 5; cs++) begin
            int dv;
            dv = (cs == 1) ? 1 : (cs == 2) ? 8 : (cs == 3) ? 64 : (cs == 4) ? 256 : 1024;
            wr_cfg(3'(cs), 3'b011, 2'b10);
            cycles_to_change(n);
            check(n == dv, "R3 first tick after code change", n, dv);
            cycles_to_change(n);
            check(n == dv, "R3 tick period", n, dv);
        end
        repeat (500) @(negedge clk);
        wr_cfg(3'b101, 3'b011, 2'b10);
        cycles_to_change(n);
        check(n == 523, "R3 same code keeps prescaler phase", n, 523);

        // R4: external rising edges
        wr_cfg(3'b111, 3'b011, 2'b10);
        repeat (4) @(negedge clk);
        c = count;
        ext_pin = 1'b1;
        repeat (2) @(negedge clk);
        check(count == c, "R4 no increment before third edge", int'(count), int'(c));
        @(negedge clk);
        check(count == 8'(c + 1), "R4 increment at third edge", int'(count), int'(c) + 1);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        c = count;
        pulse_pin(5);
        repeat (4) @(negedge clk);
        check(count == 8'(c + 5), "R4 rising edges counted once each", int'(count), int'(c) + 5);

        // R4: external falling edges
        wr_cfg(3'b110, 3'b011, 2'b10);
        repeat (4) @(negedge clk);
        c = count;
        pulse_pin(4);
        repeat (4) @(negedge clk);
        check(count == 8'(c + 4), "R4 falling edges counted once each", int'(count), int'(c) + 4);
        c = count;
        ext_pin = 1'b1;
        repeat (6) @(negedge clk);
        check(count == c, "R4 rising edge ignored in falling mode", int'(count), int'(c));
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule